// File: doc/BRIEF.md
# Supervisor Status and Trap Controller

This block keeps the privileged control state of a small RISC core: the status word, the cause word (interrupt-pending bits plus an exception code), the exception PC, the exception vector and the bad-address capture. It decides when the core leaves its normal instruction stream. A synchronous trap request from the pipeline redirects the core. So does a pending interrupt that is both unmasked and globally enabled. On the edge where either is accepted, the block saves the interrupted PC and the faulting address. It updates the privilege bits and sends a redirect to the exception vector.

Software writes to the status word pass through a sanitiser before they are stored. Bits that have no meaning always read as zero. Bits for optional features that this build leaves out (64-bit integer mode, floating point, compressed instructions, vector unit) are also forced to zero. Every change to the status word sends a one-cycle TLB-flush strobe. It also updates the address-translation enable and privilege outputs, and the integer width selected for the current mode. An inter-processor interrupt line marks its own pending bit and wakes the core through a run flag.

Top module: `trap_status_ctrl`

## Requirements
- R1: After reset the status word holds only the supervisor bit (bit 5) and the supervisor-64 bit (bit 7), which gives 0xA0 in a 64-bit build and 0x20 in a 32-bit build. The cause, exception PC, vector, bad address and redirect PC are zero, and the redirect, flush and run outputs are low.
- R2: A status write stores the written data one edge later, with every always-zero bit cleared. The bits that can be kept are trap enable (0), floating point (1), compressed (2), vector (3), previous supervisor (4), supervisor (5), user-64 (6), supervisor-64 (7), translation enable (8) and the interrupt mask (bits 16 and up, one bit per pending bit).
- R3: An enable bit for a feature that is not configured always reads zero. In the default build compressed instructions (bit 2) are absent. A 32-bit build also clears bits 6 and 7.
- R4: Each accepted status write or trap entry raises tlb_flush for exactly the following cycle. vm_en and sup_mode follow status bits 8 and 5.
- R5: xlen_o is 64 when the 64-bit bit of the current mode is set, and 32 otherwise. Bit 7 is that bit in supervisor mode and bit 6 in user mode.
- R6: An interrupt is entered when the pending field ANDed with the mask field is nonzero and trap enable is set. Entry writes exception code 31. Nothing is entered when the pending bit is masked or trap enable is clear.
- R7: Trap entry copies the old supervisor bit into bit 4, sets bit 5 and clears bit 0.
- R8: Trap entry writes the exception code into cause bits [6:2] and keeps the pending bits [31:24]. It captures cur_pc as the exception PC and fault_addr as the bad address. For one cycle it raises redir_vld, with redir_pc set to the vector held before the edge (the vector is loaded by evec_wr_en).
- R9: An inter-processor interrupt sets pending bit 1 (cause bit 25) and sets core_run, which then stays high.
- R10: When a trap request and a status write arrive on the same edge, the trap wins and the written data is dropped.
- R11: irq_set ORs bits into the pending field and irq_clr clears them. When both act on the same bit, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sr_wr_en | input | 1 | Status write strobe |
| sr_wr_data | input | 32 | Status write data |
| evec_wr_en | input | 1 | Exception vector write strobe |
| evec_wr_data | input | AW | Exception vector write data |
| trap_req | input | 1 | Synchronous trap request |
| trap_code | input | CODE_W | Exception code of the trap |
| cur_pc | input | AW | PC of the current instruction |
| fault_addr | input | AW | Faulting address from the memory unit |
| irq_set | input | PEND_W | Pending bits to set |
| irq_clr | input | PEND_W | Pending bits to clear |
| ipi | input | 1 | Inter-processor interrupt pulse |
| status_o | output | 32 | Status word |
| cause_o | output | 32 | Cause word |
| epc_o | output | AW | Exception PC |
| evec_o | output | AW | Exception vector |
| badaddr_o | output | AW | Captured faulting address |
| redir_vld | output | 1 | PC redirect strobe |
| redir_pc | output | AW | Redirect target |
| tlb_flush | output | 1 | TLB flush strobe |
| vm_en | output | 1 | Address translation enable |
| sup_mode | output | 1 | Supervisor privilege |
| fpu_en | output | 1 | Floating point enable |
| cmp_en | output | 1 | Compressed instruction enable |
| vec_en | output | 1 | Vector unit enable |
| xlen_o | output | 7 | Active integer width, 32 or 64 |
| core_run | output | 1 | Core run flag |

## Verification
Status writes, trap requests, IPIs and pending-bit changes all show on the outputs after exactly one edge, and redir_vld and tlb_flush stay high for that single cycle only. An interrupt needs two edges: the first registers the pending bit and the second performs the entry. So the bench checks the cycle after the first edge for the absence of a redirect, and the cycle after the second for its presence. Inputs change on the falling edge and outputs are read on the next falling edge, so every check lands half a period after the edge that should have produced its value.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int SR_W   = 32;
    localparam int CS_W   = 32;
    // status bit positions
    localparam int B_TE   = 0;
    localparam int B_FP   = 1;
    localparam int B_CI   = 2;
    localparam int B_VE   = 3;
    localparam int B_PS   = 4;
    localparam int B_SU   = 5;
    localparam int B_UW   = 6;
    localparam int B_SW   = 7;
    localparam int B_VM   = 8;
    localparam int IM_LSB = 16;
    localparam int IM_MAX = 16;
endpackage

// File: rtl/tsc_status_filter.sv
module tsc_status_filter
    import tsc_pkg::*;
#(
    parameter bit HAS_64  = 1'b1,
    parameter bit HAS_FPU = 1'b1,
    parameter bit HAS_CMP = 1'b0,
    parameter bit HAS_VEC = 1'b1,
    parameter int IM_W    = 8
) (
    input  logic [SR_W-1:0] raw,
    output logic [SR_W-1:0] clean
);
    localparam logic [SR_W-1:0] IM_BITS = ((32'h1 << IM_W) - 32'h1) << IM_LSB;
    localparam logic [SR_W-1:0] BASE_BITS = (32'h1 << B_TE) | (32'h1 << B_PS)
                                          | (32'h1 << B_SU) | (32'h1 << B_VM) | IM_BITS;
    localparam logic [SR_W-1:0] W64_BITS = HAS_64 ? ((32'h1 << B_UW) | (32'h1 << B_SW)) : 32'h0;
    localparam logic [SR_W-1:0] FPU_BITS = HAS_FPU ? (32'h1 << B_FP) : 32'h0;
    localparam logic [SR_W-1:0] CMP_BITS = HAS_CMP ? (32'h1 << B_CI) : 32'h0;
    localparam logic [SR_W-1:0] VEC_BITS = HAS_VEC ? (32'h1 << B_VE) : 32'h0;
    localparam logic [SR_W-1:0] KEEP = BASE_BITS | W64_BITS | FPU_BITS | CMP_BITS | VEC_BITS;

    assign clean = raw & KEEP;
endmodule

// File: rtl/tsc_irq_check.sv
module tsc_irq_check #(
    parameter int PEND_W = 8
) (
    input  logic [PEND_W-1:0] pend,
    input  logic [PEND_W-1:0] mask,
    input  logic              trap_en,
    output logic              ready
);
    logic [PEND_W-1:0] live;

    assign live  = pend & mask;
    assign ready = trap_en & (|live);
endmodule

// File: rtl/tsc_xlen_sel.sv
module tsc_xlen_sel (
    input  logic       sup,
    input  logic       user_w64,
    input  logic       sup_w64,
    output logic [6:0] width
);
    logic is64;

    assign is64  = sup ? sup_w64 : user_w64;
    assign width = is64 ? 7'd64 : 7'd32;
endmodule

// File: rtl/trap_status_ctrl.sv
module trap_status_ctrl
    import tsc_pkg::*;
#(
    parameter int AW       = 64,
    parameter int PEND_W   = 8,
    parameter int PEND_LSB = 24,
    parameter int CODE_W   = 5,
    parameter int CODE_LSB = 2,
    parameter int IPI_BIT  = 1,
    parameter int INT_CODE = 31,
    parameter bit HAS_64   = 1'b1,
    parameter bit HAS_FPU  = 1'b1,
    parameter bit HAS_CMP  = 1'b0,
    parameter bit HAS_VEC  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_wr_en,
    input  logic [SR_W-1:0]   sr_wr_data,
    input  logic              evec_wr_en,
    input  logic [AW-1:0]     evec_wr_data,
    input  logic              trap_req,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [AW-1:0]     cur_pc,
    input  logic [AW-1:0]     fault_addr,
    input  logic [PEND_W-1:0] irq_set,
    input  logic [PEND_W-1:0] irq_clr,
    input  logic              ipi,
    output logic [SR_W-1:0]   status_o,
    output logic [CS_W-1:0]   cause_o,
    output logic [AW-1:0]     epc_o,
    output logic [AW-1:0]     evec_o,
    output logic [AW-1:0]     badaddr_o,
    output logic              redir_vld,
    output logic [AW-1:0]     redir_pc,
    output logic              tlb_flush,
    output logic              vm_en,
    output logic              sup_mode,
    output logic              fpu_en,
    output logic              cmp_en,
    output logic              vec_en,
    output logic [6:0]        xlen_o,
    output logic              core_run
);
    localparam logic [PEND_W-1:0] IPI_MASK  = {{(PEND_W-1){1'b0}}, 1'b1} << IPI_BIT;
    localparam logic [CODE_W-1:0] IRQ_CODE  = CODE_W'(INT_CODE);
    localparam logic [SR_W-1:0]   RESET_RAW = (32'h1 << B_SU) | (32'h1 << B_SW);

    typedef struct packed {
        logic [SR_W-1:0]   sr;
        logic [PEND_W-1:0] pend;
        logic [CODE_W-1:0] code;
        logic [AW-1:0]     epc;
        logic [AW-1:0]     evec;
        logic [AW-1:0]     badaddr;
        logic [AW-1:0]     rpc;
        logic              rvld;
        logic              flush;
        logic              run;
    } tsc_state_t;

    tsc_state_t state_d, state_q;

    logic [SR_W-1:0]   wr_clean;
    logic [SR_W-1:0]   rst_sr;
    logic [PEND_W-1:0] im_field;
    logic              irq_ready;
    logic              enter;
    logic [SR_W-1:0]   trap_sr;

    // sanitiser for software writes
    tsc_status_filter #(
        .HAS_64 (HAS_64), .HAS_FPU(HAS_FPU), .HAS_CMP(HAS_CMP),
        .HAS_VEC(HAS_VEC), .IM_W   (PEND_W)
    ) u_wr_filt (
        .raw  (sr_wr_data),
        .clean(wr_clean)
    );

    // same sanitiser applied to the boot value
    tsc_status_filter #(
        .HAS_64 (HAS_64), .HAS_FPU(HAS_FPU), .HAS_CMP(HAS_CMP),
        .HAS_VEC(HAS_VEC), .IM_W   (PEND_W)
    ) u_rst_filt (
        .raw  (RESET_RAW),
        .clean(rst_sr)
    );

    assign im_field = state_q.sr[IM_LSB +: PEND_W];

    tsc_irq_check #(.PEND_W(PEND_W)) u_irq (
        .pend   (state_q.pend),
        .mask   (im_field),
        .trap_en(state_q.sr[B_TE]),
        .ready  (irq_ready)
    );

    tsc_xlen_sel u_xlen (
        .sup     (state_q.sr[B_SU]),
        .user_w64(state_q.sr[B_UW]),
        .sup_w64 (state_q.sr[B_SW]),
        .width   (xlen_o)
    );

    assign enter = trap_req | irq_ready;

    always_comb begin
        trap_sr       = state_q.sr;
        trap_sr[B_TE] = 1'b0;
        trap_sr[B_PS] = state_q.sr[B_SU];
        trap_sr[B_SU] = 1'b1;
    end

    always_comb begin
        state_d       = state_q;
        state_d.rvld  = 1'b0;
        state_d.flush = 1'b0;
        state_d.pend  = (state_q.pend & ~irq_clr) | irq_set | (ipi ? IPI_MASK : '0);
        if (ipi) begin
            state_d.run = 1'b1;
        end
        if (evec_wr_en) begin
            state_d.evec = evec_wr_data;
        end
        if (enter) begin
            state_d.sr      = trap_sr;
            state_d.code    = trap_req ? trap_code : IRQ_CODE;
            state_d.epc     = cur_pc;
            state_d.badaddr = fault_addr;
            state_d.rpc     = state_q.evec;
            state_d.rvld    = 1'b1;
            state_d.flush   = 1'b1;
        end else if (sr_wr_en) begin
            state_d.sr    = wr_clean;
            state_d.flush = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.sr <= rst_sr;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cause_o = '0;
        cause_o[PEND_LSB +: PEND_W] = state_q.pend;
        cause_o[CODE_LSB +: CODE_W] = state_q.code;
    end

    assign status_o  = state_q.sr;
    assign epc_o     = state_q.epc;
    assign evec_o    = state_q.evec;
    assign badaddr_o = state_q.badaddr;
    assign redir_vld = state_q.rvld;
    assign redir_pc  = state_q.rpc;
    assign tlb_flush = state_q.flush;
    assign vm_en     = state_q.sr[B_VM];
    assign sup_mode  = state_q.sr[B_SU];
    assign fpu_en    = state_q.sr[B_FP];
    assign cmp_en    = state_q.sr[B_CI];
    assign vec_en    = state_q.sr[B_VE];
    assign core_run  = state_q.run;
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk
    import tsc_pkg::*;
#(
    parameter int AW       = 64,
    parameter int PEND_W   = 8,
    parameter int PEND_LSB = 24,
    parameter int CODE_W   = 5,
    parameter int CODE_LSB = 2,
    parameter int IPI_BIT  = 1,
    parameter int INT_CODE = 31,
    parameter bit HAS_CMP  = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sr_wr_en,
    input logic            trap_req,
    input logic            ipi,
    input logic [AW-1:0]   cur_pc,
    input logic [SR_W-1:0] status_o,
    input logic [CS_W-1:0] cause_o,
    input logic [AW-1:0]   epc_o,
    input logic [AW-1:0]   evec_o,
    input logic            redir_vld,
    input logic [AW-1:0]   redir_pc,
    input logic            tlb_flush,
    input logic            core_run
);
    logic [PEND_W-1:0] pend_v;
    logic [PEND_W-1:0] mask_v;
    logic [CODE_W-1:0] code_v;

    assign pend_v = cause_o[PEND_LSB +: PEND_W];
    assign mask_v = status_o[IM_LSB +: PEND_W];
    assign code_v = cause_o[CODE_LSB +: CODE_W];

    // R7
    trap_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (!status_o[B_TE] && status_o[B_SU] && (status_o[B_PS] == $past(status_o[B_SU]))));

    // R4
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en || trap_req) |=> tlb_flush);

    // R8
    trap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (redir_vld && (epc_o == $past(cur_pc)) && (redir_pc == $past(evec_o))));

    // R9
    ipi_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ipi |=> (core_run && cause_o[PEND_LSB + IPI_BIT]));

    // R3
    absent_feature_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!HAS_CMP && status_o[B_CI]));

    // R6
    irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && status_o[B_TE] && ((pend_v & mask_v) != '0))
        |=> (redir_vld && (code_v == CODE_W'(INT_CODE))));

    // R10
    trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && sr_wr_en) |=> (!status_o[B_TE] && status_o[B_SU]));
endmodule

bind trap_status_ctrl tsc_chk #(
    .AW(AW), .PEND_W(PEND_W), .PEND_LSB(PEND_LSB), .CODE_W(CODE_W),
    .CODE_LSB(CODE_LSB), .IPI_BIT(IPI_BIT), .INT_CODE(INT_CODE), .HAS_CMP(HAS_CMP)
) u_tsc_chk (
    .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .trap_req(trap_req), .ipi(ipi),
    .cur_pc(cur_pc), .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o),
    .evec_o(evec_o), .redir_vld(redir_vld), .redir_pc(redir_pc),
    .tlb_flush(tlb_flush), .core_run(core_run)
);

// File: tb/test_trap_status_ctrl.sv
`timescale 1ns/1ps
module test_trap_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_wr_en = 1'b0;
    logic [31:0] sr_wr_data = '0;
    logic        evec_wr_en = 1'b0;
    logic [63:0] evec_wr_data = '0;
    logic        trap_req = 1'b0;
    logic [4:0]  trap_code = '0;
    logic [63:0] cur_pc = '0;
    logic [63:0] fault_addr = '0;
    logic [7:0]  irq_set = '0;
    logic [7:0]  irq_clr = '0;
    logic        ipi = 1'b0;

    logic [31:0] status_o, cause_o;
    logic [63:0] epc_o, evec_o, badaddr_o, redir_pc;
    logic        redir_vld, tlb_flush, vm_en, sup_mode, fpu_en, cmp_en, vec_en, core_run;
    logic [6:0]  xlen_o;

    logic [31:0] n_status, n_cause;
    logic [63:0] n_epc, n_evec, n_bad, n_rpc;
    logic        n_rvld, n_flush, n_vm, n_sup, n_fpu, n_cmp, n_vec, n_run;
    logic [6:0]  n_xlen;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    trap_status_ctrl i_trap_status_ctrl (
        .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .evec_wr_en(evec_wr_en), .evec_wr_data(evec_wr_data), .trap_req(trap_req),
        .trap_code(trap_code), .cur_pc(cur_pc), .fault_addr(fault_addr),
        .irq_set(irq_set), .irq_clr(irq_clr), .ipi(ipi),
        .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o), .evec_o(evec_o),
        .badaddr_o(badaddr_o), .redir_vld(redir_vld), .redir_pc(redir_pc),
        .tlb_flush(tlb_flush), .vm_en(vm_en), .sup_mode(sup_mode), .fpu_en(fpu_en),
        .cmp_en(cmp_en), .vec_en(vec_en), .xlen_o(xlen_o), .core_run(core_run)
    );

    trap_status_ctrl #(.HAS_64(1'b0)) i_trap_status_ctrl_n64 (
        .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .evec_wr_en(evec_wr_en), .evec_wr_data(evec_wr_data), .trap_req(trap_req),
        .trap_code(trap_code), .cur_pc(cur_pc), .fault_addr(fault_addr),
        .irq_set(irq_set), .irq_clr(irq_clr), .ipi(ipi),
        .status_o(n_status), .cause_o(n_cause), .epc_o(n_epc), .evec_o(n_evec),
        .badaddr_o(n_bad), .redir_vld(n_rvld), .redir_pc(n_rpc),
        .tlb_flush(n_flush), .vm_en(n_vm), .sup_mode(n_sup), .fpu_en(n_fpu),
        .cmp_en(n_cmp), .vec_en(n_vec), .xlen_o(n_xlen), .core_run(n_run)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sr_write(input logic [31:0] data);
        sr_wr_en   = 1'b1;
        sr_wr_data = data;
        @(negedge clk);
        sr_wr_en   = 1'b0;
    endtask

    task automatic do_trap(input logic [4:0] code, input logic [63:0] pc, input logic [63:0] fa);
        trap_req   = 1'b1;
        trap_code  = code;
        cur_pc     = pc;
        fault_addr = fa;
        @(negedge clk);
        trap_req   = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", status_o, 32'hA0);
        chk("R1 cause", cause_o, 0);
        chk("R1 epc", epc_o, 0);
        chk("R1 evec", evec_o, 0);
        chk("R1 redir_pc", redir_pc, 0);
        chk("R1 redir_vld", redir_vld, 0);
        chk("R1 flush", tlb_flush, 0);
        chk("R1 run", core_run, 0);
        chk("R1 xlen", xlen_o, 64);
        chk("R3 r32 reset status", n_status, 32'h20);
        chk("R3 r32 reset xlen", n_xlen, 32);
    endtask

    task automatic t_write;
        sr_write(32'hFFFF_FFFF);
        chk("R2 masked write", status_o, 32'h00FF_01FB);
        chk("R3 compressed off", cmp_en, 0);
        chk("R3 r32 clears wide bits", n_status, 32'h00FF_013B);
        chk("R4 flush pulse", tlb_flush, 1);
        chk("R4 vm_en", vm_en, 1);
        chk("R4 sup_mode", sup_mode, 1);
        @(negedge clk);
        chk("R4 flush one cycle", tlb_flush, 0);
    endtask

    task automatic t_xlen;
        sr_write(32'h40);
        chk("R5 user wide", xlen_o, 64);
        chk("R4 sup_mode low", sup_mode, 0);
        chk("R3 r32 user width", n_xlen, 32);
        sr_write(32'h80);
        chk("R5 user narrow with sup bit", xlen_o, 32);
        sr_write(32'hA0);
        chk("R5 sup wide", xlen_o, 64);
        sr_write(32'h20);
        chk("R5 sup narrow", xlen_o, 32);
    endtask

    task automatic t_trap;
        evec_wr_en   = 1'b1;
        evec_wr_data = 64'h1000;
        @(negedge clk);
        evec_wr_en   = 1'b0;
        chk("R8 vector load", evec_o, 64'h1000);
        sr_write(32'h01);
        do_trap(5'd5, 64'h400, 64'hDEAD);
        chk("R7 status from user", status_o, 32'h20);
        chk("R8 cause code", cause_o, 32'h14);
        chk("R8 epc", epc_o, 64'h400);
        chk("R8 redir_vld", redir_vld, 1);
        chk("R8 redir_pc", redir_pc, 64'h1000);
        chk("R8 badaddr", badaddr_o, 64'hDEAD);
        chk("R4 flush on trap", tlb_flush, 1);
        @(negedge clk);
        chk("R8 redir one cycle", redir_vld, 0);
        do_trap(5'd6, 64'h404, 64'hBEEF);
        chk("R7 status from sup", status_o, 32'h30);
        chk("R8 cause code 2", cause_o, 32'h18);
        chk("R8 epc 2", epc_o, 64'h404);
    endtask

    task automatic t_pending;
        irq_set = 8'h08;
        @(negedge clk);
        irq_set = 8'h00;
        chk("R11 set", cause_o, 32'h0800_0018);
        do_trap(5'd2, 64'h500, 64'h0);
        chk("R8 pending kept", cause_o, 32'h0800_0008);
        irq_set = 8'h08;
        irq_clr = 8'h08;
        @(negedge clk);
        irq_set = 8'h00;
        chk("R11 set wins", cause_o, 32'h0800_0008);
        @(negedge clk);
        irq_clr = 8'h00;
        chk("R11 clear", cause_o, 32'h0000_0008);
    endtask

    task automatic t_irq;
        sr_write(32'h0001_0021);
        irq_set = 8'h04;
        @(negedge clk);
        irq_set = 8'h00;
        chk("R11 masked pending", cause_o, 32'h0400_0008);
        @(negedge clk);
        chk("R6 masked no entry", redir_vld, 0);
        irq_set = 8'h01;
        @(negedge clk);
        irq_set = 8'h00;
        chk("R6 no entry before pending registered", redir_vld, 0);
        @(negedge clk);
        chk("R6 entry", redir_vld, 1);
        chk("R6 code", cause_o, 32'h0500_007C);
        chk("R6 status", status_o, 32'h0001_0030);
        @(negedge clk);
        chk("R6 trap enable clear blocks", redir_vld, 0);
    endtask

    task automatic t_ipi;
        ipi = 1'b1;
        @(negedge clk);
        ipi = 1'b0;
        chk("R9 run", core_run, 1);
        chk("R9 pending", cause_o, 32'h0700_007C);
        @(negedge clk);
        chk("R9 run sticky", core_run, 1);
    endtask

    task automatic t_prio;
        sr_write(32'h01);
        chk("R2 plain write", status_o, 32'h01);
        sr_wr_en   = 1'b1;
        sr_wr_data = 32'hA1;
        do_trap(5'd7, 64'h88, 64'h0);
        sr_wr_en   = 1'b0;
        chk("R10 trap wins", status_o, 32'h20);
        chk("R10 cause", cause_o, 32'h0700_001C);
        chk("R10 epc", epc_o, 64'h88);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_xlen();
        t_trap();
        t_pending();
        t_irq();
        t_ipi();
        t_prio();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule